// File: doc/BRIEF.md
# Line-Cycle Synchronized Energy Accumulator

This block sums a stream of per-sample power values over a window that is a whole number of mains half-cycles. Window edges come from a one-clock zero-crossing strobe, and samples come with a one-clock valid strobe. At the crossing that closes a window, the block does three things:

- it copies the upper part of a wide running sum into a readable result register;
- it raises an end-of-window status flag;
- it starts the next window with no gap.

Either of two sample streams can be summed: apparent power or RMS current. A mode bit picks the stream, and the choice does not change any timing.

A small write port sets the window length in half-cycles. The same port sets the source and the interrupt enable, and clears the flag. Writing a new length discards the current sum. The next crossing starts a fresh window, so the first end-of-window event after that write already holds a complete measurement. A combinational read port returns any register.

Top module: `linecyc_energy_acc`

## Requirements
- R1: After reset, every register reads zero: window length, control, status and result. The interrupt output is low.
- R2: A write to address 0 makes the result read zero from the next cycle. The new window opens at the next zero crossing. Samples between the write and that crossing are left out of every sum.
- R3: A window that opens at a crossing closes at the Nth later crossing, where N is the programmed length. The result then reads bits 47..24 of the 48-bit sum of the valid samples from the opening crossing's cycle up to the cycle before the closing crossing. Status bit 0 goes to 1 on the same edge.
- R4: A closing crossing also opens the next window at once. A valid sample in the same cycle as a closing crossing is counted in the new window.
- R5: Control bit 0 selects the source: 0 sums the apparent-power input, 1 sums the RMS-current input.
- R6: The interrupt output is high exactly when status bit 0 is 1 and control bit 1 (interrupt enable) is 1.
- R7: Status bit 0 clears when 1 is written to bit 0 of address 2; writing 0 leaves it. A window end in the same cycle as a clearing write leaves the flag set.
- R8: A window length of zero keeps the block idle. No sum is kept, no window ends and the result stays zero.
- R9: A window that ends while the flag is still set overwrites the result, and the flag stays set.
- R10: The window length is an unsigned 16-bit value read back at address 0. A length of 65535 gives a window of 65535 half-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zx_stb | input | 1 | Zero-crossing strobe, one cycle wide |
| smp_vld | input | 1 | Sample-valid strobe, one cycle wide |
| smp_va | input | 32 | Apparent-power sample |
| smp_irms | input | 32 | RMS-current sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 length, 1 control, 2 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 length, 1 control, 2 status, 3 result |
| rd_data | output | 24 | Read data, zero-extended |
| irq | output | 1 | End-of-window interrupt, active high |

## Verification
The assertions assume the following about the inputs:

- the programmed length only changes through an address-0 write;
- a running window therefore always has a nonzero length, so the half-cycle counter stays below it;
- strobes are sampled at clock edges, and there is at most one register write per cycle.

The bench drives all inputs from the falling edge and issues one write per cycle. Random phases pick window lengths from 0 to 5 and fire crossings often, so windows close many times. They also mix clearing writes and length writes into running windows. Directed cases cover the collisions:

- a clearing write in the same cycle as a window end;
- a sample in the same cycle as a closing crossing;
- the full 16-bit length.

// File: rtl/lc_pkg.sv
package lc_pkg;

  typedef enum logic [1:0] {
    ACC_HOLD  = 2'd0,
    ACC_CLEAR = 2'd1,
    ACC_LOAD  = 2'd2,
    ACC_ADD   = 2'd3
  } acc_op_e;

  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_ARMED = 2'd1,
    WIN_RUN   = 2'd2
  } win_state_e;

  localparam logic [1:0] ADDR_LEN    = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_RESULT = 2'd3;

  localparam int CTRL_SRC_BIT = 0;
  localparam int CTRL_IEN_BIT = 1;
  localparam int STAT_END_BIT = 0;

endpackage

// File: rtl/lc_host_regs.sv
module lc_host_regs
  import lc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             end_set,
  output logic [CNT_W-1:0] target,
  output logic             src_irms,
  output logic             irq_en,
  output logic             end_flag,
  output logic             len_wr
);

  logic [CNT_W-1:0] target_q, target_d;
  logic             src_q, src_d;
  logic             ien_q, ien_d;
  logic             flag_q, flag_d;
  logic             ctrl_wr, stat_clr;

  always_comb begin
    len_wr   = wr_en && (wr_addr == ADDR_LEN);
    ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    stat_clr = wr_en && (wr_addr == ADDR_STATUS) && wr_data[STAT_END_BIT];

    target_d = target_q;
    src_d    = src_q;
    ien_d    = ien_q;
    if (len_wr) begin
      target_d = wr_data;
    end
    if (ctrl_wr) begin
      src_d = wr_data[CTRL_SRC_BIT];
      ien_d = wr_data[CTRL_IEN_BIT];
    end

    // a window end beats a clearing write in the same cycle
    if (end_set) begin
      flag_d = 1'b1;
    end else if (stat_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
    end else if (len_wr) begin
      target_q <= target_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (ctrl_wr) begin
      src_q <= src_d;
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign target   = target_q;
  assign src_irms = src_q;
  assign irq_en   = ien_q;
  assign end_flag = flag_q;

endmodule

// File: rtl/lc_window_ctrl.sv
module lc_window_ctrl
  import lc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic             len_zero,
  input  logic             zx_stb,
  input  logic             smp_vld,
  input  logic [CNT_W-1:0] target,
  output acc_op_e          acc_op,
  output logic             win_end,
  output logic             running,
  output logic [CNT_W-1:0] hc_cnt
);

  win_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_en;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_op  = ACC_HOLD;
    win_end = 1'b0;

    if (len_wr) begin
      // a length write wins over a crossing in the same cycle
      state_d = len_zero ? WIN_IDLE : WIN_ARMED;
      cnt_d   = '0;
      acc_op  = ACC_CLEAR;
    end else begin
      unique case (state_q)
        WIN_ARMED: begin
          if (zx_stb) begin
            state_d = WIN_RUN;
            cnt_d   = '0;
            acc_op  = smp_vld ? ACC_LOAD : ACC_CLEAR;
          end
        end
        WIN_RUN: begin
          if (zx_stb) begin
            if (cnt_inc == target) begin
              win_end = 1'b1;
              cnt_d   = '0;
              acc_op  = smp_vld ? ACC_LOAD : ACC_CLEAR;
            end else begin
              cnt_d  = cnt_inc;
              acc_op = smp_vld ? ACC_ADD : ACC_HOLD;
            end
          end else if (smp_vld) begin
            acc_op = ACC_ADD;
          end
        end
        default: begin
          state_d = WIN_IDLE;
        end
      endcase
    end
  end

  assign cnt_en = len_wr || zx_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign running = (state_q == WIN_RUN);
  assign hc_cnt  = cnt_q;

endmodule

// File: rtl/lc_accum.sv
module lc_accum
  import lc_pkg::*;
#(
  parameter int SMP_W = 32,
  parameter int ACC_W = 48,
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_op_e          acc_op,
  input  logic             res_latch,
  input  logic             res_clr,
  input  logic [SMP_W-1:0] smp,
  output logic [RES_W-1:0] result
);

  localparam int PAD_W = ACC_W - SMP_W;

  logic [ACC_W-1:0] acc_q, acc_d, smp_ext;
  logic [RES_W-1:0] res_q, res_d;
  logic             acc_en, res_en;

  generate
    if (PAD_W > 0) begin : g_pad
      assign smp_ext = {{PAD_W{1'b0}}, smp};
    end else begin : g_trunc
      assign smp_ext = smp[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (acc_op)
      ACC_CLEAR: acc_d = '0;
      ACC_LOAD:  acc_d = smp_ext;
      ACC_ADD:   acc_d = acc_q + smp_ext;
      default:   acc_d = acc_q;
    endcase
    acc_en = (acc_op != ACC_HOLD);

    if (res_clr) begin
      res_d = '0;
    end else begin
      res_d = acc_q[ACC_W-1 -: RES_W];
    end
    res_en = res_clr || res_latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign result = res_q;

endmodule

// File: rtl/linecyc_energy_acc.sv
module linecyc_energy_acc
  import lc_pkg::*;
#(
  parameter int SMP_W = 32,
  parameter int ACC_W = 48,
  parameter int RES_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zx_stb,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_va,
  input  logic [SMP_W-1:0] smp_irms,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [RES_W-1:0] rd_data,
  output logic             irq
);

  logic [CNT_W-1:0] w_target;
  logic [CNT_W-1:0] w_hc_cnt;
  logic             w_src_irms;
  logic             w_ien;
  logic             w_flag;
  logic             w_len_wr;
  logic             w_win_end;
  logic             w_running;
  acc_op_e          w_acc_op;
  logic [SMP_W-1:0] w_smp;
  logic [RES_W-1:0] w_result;

  lc_host_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .end_set  (w_win_end),
    .target   (w_target),
    .src_irms (w_src_irms),
    .irq_en   (w_ien),
    .end_flag (w_flag),
    .len_wr   (w_len_wr)
  );

  lc_window_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_wr   (w_len_wr),
    .len_zero (wr_data == '0),
    .zx_stb   (zx_stb),
    .smp_vld  (smp_vld),
    .target   (w_target),
    .acc_op   (w_acc_op),
    .win_end  (w_win_end),
    .running  (w_running),
    .hc_cnt   (w_hc_cnt)
  );

  assign w_smp = w_src_irms ? smp_irms : smp_va;

  lc_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W), .RES_W(RES_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_op    (w_acc_op),
    .res_latch (w_win_end),
    .res_clr   (w_len_wr),
    .smp       (w_smp),
    .result    (w_result)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_LEN:    rd_data[CNT_W-1:0] = w_target;
      ADDR_CTRL: begin
        rd_data[CTRL_SRC_BIT] = w_src_irms;
        rd_data[CTRL_IEN_BIT] = w_ien;
      end
      ADDR_STATUS: rd_data[STAT_END_BIT] = w_flag;
      default:     rd_data = w_result;
    endcase
  end

  assign irq = w_flag & w_ien;

endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int CNT_W = 16,
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             len_wr,
  input logic             win_end,
  input logic             end_flag,
  input logic             irq,
  input logic             irq_en,
  input logic             running,
  input logic [CNT_W-1:0] target,
  input logic [CNT_W-1:0] hc_cnt,
  input logic [RES_W-1:0] result
);

  assert_result_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr |=> (result == '0));

  assert_flag_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> end_flag);

  assert_result_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !len_wr) |=> $stable(result));

  assert_irq_rise_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (irq_en && end_flag));

  assert_no_end_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (target == '0) |-> !win_end);

  assert_cnt_below_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (hc_cnt < target));

endmodule

bind linecyc_energy_acc lc_checker #(.CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .len_wr   (w_len_wr),
  .win_end  (w_win_end),
  .end_flag (w_flag),
  .irq      (irq),
  .irq_en   (w_ien),
  .running  (w_running),
  .target   (w_target),
  .hc_cnt   (w_hc_cnt),
  .result   (w_result)
);

// File: tb/linecyc_energy_acc_test.sv
module linecyc_energy_acc_test;

  logic        clk, rst_n;
  logic        zx_stb, smp_vld, wr_en;
  logic [31:0] smp_va, smp_irms;
  logic [1:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [23:0] rd_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model, built from the requirements
  logic [15:0] m_len;
  bit          m_src, m_ien, m_flag, m_run;
  int          m_cnt;
  logic [47:0] m_sum;
  logic [23:0] m_res;

  linecyc_energy_acc uut (
    .clk(clk), .rst_n(rst_n), .zx_stb(zx_stb), .smp_vld(smp_vld),
    .smp_va(smp_va), .smp_irms(smp_irms), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [23:0] upper_of(input logic [47:0] s);
    return s[47:24];
  endfunction

  function automatic logic [47:0] cur_sample();
    return {16'h0, (m_src ? smp_irms : smp_va)};
  endfunction

  task automatic model_step();
    logic [47:0] s;
    bit ended;
    s = smp_vld ? cur_sample() : 48'h0;
    ended = 0;
    if (wr_en && wr_addr == 2'd0) begin
      m_len = wr_data; m_run = 0; m_cnt = 0; m_sum = 0; m_res = 0;
    end else if (!m_run) begin
      if (zx_stb && m_len != 0) begin m_run = 1; m_cnt = 0; m_sum = s; end
    end else if (zx_stb) begin
      if (m_cnt + 1 == int'(m_len)) begin
        m_res = upper_of(m_sum); ended = 1; m_sum = s; m_cnt = 0;
      end else begin
        m_cnt++; m_sum = m_sum + s;
      end
    end else begin
      m_sum = m_sum + s;
    end
    if (ended) m_flag = 1;
    else if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_flag = 0;
    if (wr_en && wr_addr == 2'd1) begin m_src = wr_data[0]; m_ien = wr_data[1]; end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    zx_stb = 0; smp_vld = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [23:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic chk_model(input string req);
    logic [23:0] v;
    rd(2'd3, v); chk(req, "result", v, m_res);
    rd(2'd2, v); chk(req, "flag", v, {23'h0, m_flag});
    chk(req, "irq", irq, m_flag & m_ien);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
  endtask

  task automatic smp(input bit z, input bit v, input logic [31:0] a, input logic [31:0] i);
    zx_stb = z; smp_vld = v; smp_va = a; smp_irms = i;
    tick();
  endtask

  initial begin
    logic [23:0] v;
    void'($urandom(32'd1234));
    rst_n = 0; zx_stb = 0; smp_vld = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    smp_va = 0; smp_irms = 0; rd_addr = 0;
    m_len = 0; m_src = 0; m_ien = 0; m_flag = 0; m_run = 0; m_cnt = 0;
    m_sum = 0; m_res = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1", "reset reg", v, 24'h0);
    end
    chk("R1", "reset irq", irq, 1'b0);

    // R2/R3 directed window of length 2
    wr(2'd0, 16'd2);
    wr(2'd1, 16'h2);
    rd(2'd0, v); chk("R10", "length readback", v, 24'd2);
    smp(0, 1, 32'd100 << 24, 0);
    smp(1, 1, 32'd1 << 24, 0);
    smp(0, 1, 32'd2 << 24, 0);
    smp(1, 1, 32'd4 << 24, 0);
    smp(0, 1, 32'd16 << 24, 0);
    rd(2'd2, v); chk("R3", "flag before end", v, 24'd0);
    smp(1, 1, 32'd8 << 24, 0);
    rd(2'd3, v); chk("R3", "window total", v, 24'd23);
    rd(2'd2, v); chk("R3", "flag after end", v, 24'd1);
    chk("R6", "irq with enable", irq, 1'b1);

    // R4 sample on the closing crossing belongs to the next window; R9 overwrite
    smp(0, 1, 32'd1 << 24, 0);
    smp(1, 0, 0, 0);
    smp(1, 1, 32'd5 << 24, 0);
    rd(2'd3, v); chk("R4", "carried sample", v, 24'd9);
    rd(2'd2, v); chk("R9", "flag still set", v, 24'd1);

    // R7 write-one-to-clear
    wr(2'd2, 16'h0);
    rd(2'd2, v); chk("R7", "write zero keeps flag", v, 24'd1);
    wr(2'd2, 16'h1);
    rd(2'd2, v); chk("R7", "write one clears", v, 24'd0);
    chk("R7", "irq after clear", irq, 1'b0);
    smp(1, 0, 0, 0);
    zx_stb = 1; wr_en = 1; wr_addr = 2'd2; wr_data = 16'h1;
    tick();
    rd(2'd2, v); chk("R7", "end beats clear", v, 24'd1);
    rd(2'd3, v); chk("R7", "result at collision", v, 24'd5);

    // R6 enable off
    wr(2'd1, 16'h0);
    chk("R6", "irq masked", irq, 1'b0);

    // R2 restart clears result; R5 source select
    wr(2'd2, 16'h1);
    wr(2'd1, 16'h1);
    wr(2'd0, 16'd1);
    rd(2'd3, v); chk("R2", "result cleared by write", v, 24'd0);
    smp(1, 1, 32'd50 << 24, 32'd3 << 24);
    smp(0, 1, 32'd60 << 24, 32'd4 << 24);
    smp(1, 0, 0, 0);
    rd(2'd3, v); chk("R5", "current source sum", v, 24'd7);

    // R8 zero length keeps block idle
    wr(2'd2, 16'h1);
    wr(2'd0, 16'd0);
    for (int i = 0; i < 40; i++) smp(1'($urandom), 1, $urandom, $urandom);
    rd(2'd2, v); chk("R8", "no event", v, 24'd0);
    rd(2'd3, v); chk("R8", "result zero", v, 24'd0);

    // R10 full 16-bit length
    wr(2'd1, 16'h0);
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R10", "max length readback", v, 24'hFFFF);
    for (int i = 0; i < 65535; i++) smp(1, 1, 32'd1 << 24, 0);
    rd(2'd2, v); chk("R10", "no end before last crossing", v, 24'd0);
    smp(1, 1, 32'd1 << 24, 0);
    rd(2'd3, v); chk("R10", "max window total", v, 24'hFFFF);
    rd(2'd2, v); chk("R10", "flag at max window", v, 24'd1);

    // random phase: R3 R4 R7 R9 against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      zx_stb = ($urandom_range(0, 7) == 0);
      smp_vld = $urandom_range(0, 1);
      smp_va = $urandom; smp_irms = $urandom;
      if (r < 2) begin
        wr_en = 1; wr_addr = 2'd0; wr_data = 16'($urandom_range(0, 5));
      end else if (r < 5) begin
        wr_en = 1; wr_addr = 2'd2; wr_data = 16'($urandom_range(0, 1));
      end else if (r < 6) begin
        wr_en = 1; wr_addr = 2'd1; wr_data = 16'($urandom_range(0, 3));
      end
      tick();
      chk_model("R3");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule